// File: doc/BRIEF.md
# Dual-Layout MDIO Management Controller

This block lets a processor reach the management registers of an Ethernet PHY over the two-wire MDC/MDIO bus. Software uses a small register port to program a 32-bit command word and a 32-bit data word. The block turns each accepted command into a Clause 22 serial frame. When the frame is done it stores any returned data and clears the command's own start bit.

Bit 31 of a feature word chooses how the command and data words are read. With the bit set, the command word carries everything, including the write data, and a read lands in the low half of the data word. With the bit clear, an older scheme applies: separate read and write request bits, write data taken from the low half of the data word, and read data placed in its high half. The MDC half-period in system clocks is taken from the low byte of the feature word when a frame starts.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Register addresses are 0 (command), 1 (data) and 2 (feature). All three read back through `reg_rdata` and reset to zero. Feature bit 31 = 1 selects the new command layout and 0 selects the legacy layout. The feature word can be written at any time.
- R2: Every frame is sent MSB first. It consists of 32 ones, start code 01, a 2-bit opcode (01 write, 10 read), a 5-bit PHY address, a 5-bit register address, a 2-bit turnaround (10 on a write) and 16 data bits.
- R3: The new-layout command word has these fields: write data [31:16], fire [15], Clause 22 enable [12], opcode [11:10], PHY address [9:5], register address [4:0]. Opcode 1 is a write and opcode 2 is a read. With fire and enable set, opcode 0 or 3 sends no frame, pulses `cmd_err` for one cycle and clears fire.
- R4: In the new layout, a command with bit 12 clear sends no frame, pulses `cmd_err` and clears fire.
- R5: In the new layout, a command with bit 12 set and fire clear does nothing: no frame and no `cmd_err`.
- R6: A new-layout read sets the data word to {16'h0, read value}.
- R7: The legacy command word has these fields: write request [27], read request [26], register address [25:21], PHY address [20:16]. A write sends data word bits [15:0]. If both request bits are set, the write is performed.
- R8: A legacy read sets the data word to {read value, 16'h0}.
- R9: A legacy command with neither request bit set sends no frame and pulses `cmd_err`.
- R10: MDC stays low when the block is idle. Each MDC phase lasts feature[7:0] clocks, and a value of 0 counts as 1. `mdio_o` changes only while MDC is low. `mdio_i` is sampled on the rising edge of MDC.
- R11: `busy` is high for exactly 128 × half-period clocks per frame, starting the cycle after the command write. On a read, `mdio_oe` is low from bit 46 (turnaround) through bit 63. `mdio_oe` is low when the block is idle.
- R12: Writes to the command register while `busy` is high are ignored.
- R13: When a frame ends, the start bit of the command is cleared: fire (bit 15) in the new layout, bits 27:26 in the legacy layout. This happens in the same cycle that `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the selected register |
| cmd_err | output | 1 | One-cycle pulse when a command is rejected |
| busy | output | 1 | A frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data in |

## Verification
Most internal faults in this block show up within one frame. A frame-bit index that is off by one shows up as a misplaced field, and the captured serial word is wrong at the first MDC rising edge after the fault. A wrong turnaround boundary shows up as a wrong `mdio_oe` pattern. A divider or end-of-frame fault changes the length of the `busy` window, and the data word read back right after `busy` falls shows whether the capture or the field placement is wrong. A decode fault appears one cycle after the command write, as an unexpected `cmd_err` or `busy` level.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    localparam int REG_W    = 32;
    localparam int DATA_W   = 16;
    localparam int ADR_W    = 5;
    localparam int PRE_LEN  = 32;
    localparam int DIV_W    = 8;
    localparam int FRAME_W  = PRE_LEN + 2 + 2 + 2 * ADR_W + 2 + DATA_W;
    localparam int TA_IDX   = PRE_LEN + 4 + 2 * ADR_W;
    localparam int DATA_IDX = TA_IDX + 2;
    localparam int IDX_W    = $clog2(FRAME_W);

    // layout selector in the feature word
    localparam int FEAT_NEW_BIT = 31;
    // new layout
    localparam int NL_FIRE = 15;
    localparam int NL_C22  = 12;
    // legacy layout
    localparam int LG_WREQ = 27;
    localparam int LG_RREQ = 26;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_DATA = 2'd1,
        RA_FEAT = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] data;
        logic [REG_W-1:0] feat;
        logic             err;
        logic             run_new;
        logic             run_rd;
        logic [DIV_W-1:0] half;
    } top_state_t;

    typedef struct packed {
        logic              busy;
        logic              mdc;
        logic              rd;
        logic [IDX_W-1:0]  idx;
        logic [FRAME_W-1:0] sh;
        logic [DATA_W-1:0] rdsh;
    } shf_state_t;
endpackage

// File: rtl/mdio_clkdiv.sv
`timescale 1ns/1ps
module mdio_clkdiv #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == half - 1'b1);
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/mdio_cmd_decode.sv
`timescale 1ns/1ps
module mdio_cmd_decode
    import mdio_pkg::*;
(
    input  logic                new_mode,
    input  logic [REG_W-1:0]    wdata,
    input  logic [DATA_W-1:0]   data_lo,
    output logic                launch,
    output logic                err,
    output logic                is_read,
    output logic [FRAME_W-1:0]  frame
);
    logic [1:0]        op;
    logic [ADR_W-1:0]  phy;
    logic [ADR_W-1:0]  rg;
    logic [DATA_W-1:0] wd;
    logic              unused_ok;

    assign unused_ok = ^wdata[14:13];

    always_comb begin
        if (new_mode) begin
            op      = wdata[11:10];
            phy     = wdata[9:5];
            rg      = wdata[4:0];
            wd      = wdata[31:16];
            is_read = (op == 2'd2);
            launch  = wdata[NL_C22] && wdata[NL_FIRE] && (op == 2'd1 || op == 2'd2);
            err     = !wdata[NL_C22] || (wdata[NL_FIRE] && !(op == 2'd1 || op == 2'd2));
        end else begin
            phy     = wdata[20:16];
            rg      = wdata[25:21];
            wd      = data_lo;
            is_read = !wdata[LG_WREQ] && wdata[LG_RREQ];
            launch  = wdata[LG_WREQ] || wdata[LG_RREQ];
            err     = !launch;
            op      = is_read ? 2'b10 : 2'b01;
        end
        frame = {{PRE_LEN{1'b1}}, 2'b01, (is_read ? 2'b10 : 2'b01), phy, rg,
                 (is_read ? 2'b11 : 2'b10), (is_read ? {DATA_W{1'b1}} : wd)};
    end

    logic unused_op;
    assign unused_op = ^op;
endmodule

// File: rtl/mdio_shifter.sv
`timescale 1ns/1ps
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic               is_read,
    input  logic               tick,
    input  logic               mdio_i,
    output logic               busy,
    output logic               mdc,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               done,
    output logic [DATA_W-1:0]  rdata
);
    shf_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (start && !s_q.busy) begin
            s_d.busy = 1'b1;
            s_d.mdc  = 1'b0;
            s_d.idx  = '0;
            s_d.sh   = frame;
            s_d.rd   = is_read;
        end else if (s_q.busy && tick) begin
            if (!s_q.mdc) begin
                s_d.mdc = 1'b1;
                if (s_q.rd && s_q.idx >= IDX_W'(DATA_IDX)) begin
                    s_d.rdsh = {s_q.rdsh[DATA_W-2:0], mdio_i};
                end
            end else begin
                s_d.mdc = 1'b0;
                if (s_q.idx == IDX_W'(FRAME_W - 1)) begin
                    s_d.busy = 1'b0;
                    done     = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                    s_d.sh  = {s_q.sh[FRAME_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = s_q.busy;
    assign mdc     = s_q.mdc;
    assign mdio_o  = s_q.busy ? s_q.sh[FRAME_W-1] : 1'b1;
    assign mdio_oe = s_q.busy && !(s_q.rd && s_q.idx >= IDX_W'(TA_IDX));
    assign rdata   = s_q.rdsh;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             cmd_err,
    output logic             busy,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    top_state_t q, d;

    logic               dec_launch, dec_err, dec_rd;
    logic [FRAME_W-1:0] dec_frame;
    logic               start, tick, done;
    logic [DATA_W-1:0]  rdata;
    logic [REG_W-1:0]   ctrl_q;

    assign ctrl_q = q.ctrl;

    mdio_cmd_decode u_dec (
        .new_mode (q.feat[FEAT_NEW_BIT]),
        .wdata    (reg_wdata),
        .data_lo  (q.data[DATA_W-1:0]),
        .launch   (dec_launch),
        .err      (dec_err),
        .is_read  (dec_rd),
        .frame    (dec_frame)
    );

    mdio_clkdiv #(.CNT_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .half  (q.half),
        .tick  (tick)
    );

    mdio_shifter u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .frame   (dec_frame),
        .is_read (dec_rd),
        .tick    (tick),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (done),
        .rdata   (rdata)
    );

    always_comb begin
        d     = q;
        d.err = 1'b0;
        start = 1'b0;

        if (done) begin
            if (q.run_new) begin
                d.ctrl[NL_FIRE] = 1'b0;
                if (q.run_rd) d.data = {{(REG_W-DATA_W){1'b0}}, rdata};
            end else begin
                d.ctrl[LG_WREQ] = 1'b0;
                d.ctrl[LG_RREQ] = 1'b0;
                if (q.run_rd) d.data = {rdata, {(REG_W-DATA_W){1'b0}}};
            end
        end

        if (reg_wr) begin
            case (reg_addr)
                RA_DATA: d.data = reg_wdata;
                RA_FEAT: d.feat = reg_wdata;
                RA_CTRL: if (!busy) begin
                    d.ctrl = reg_wdata;
                    d.err  = dec_err;
                    if (dec_launch) begin
                        start     = 1'b1;
                        d.run_new = q.feat[FEAT_NEW_BIT];
                        d.run_rd  = dec_rd;
                        d.half    = (q.feat[DIV_W-1:0] == '0) ? DIV_W'(1) : q.feat[DIV_W-1:0];
                    end else if (q.feat[FEAT_NEW_BIT]) begin
                        d.ctrl[NL_FIRE] = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = q.ctrl;
            RA_DATA: reg_rdata = q.data;
            RA_FEAT: reg_rdata = q.feat;
            default: reg_rdata = '0;
        endcase
    end

    assign cmd_err = q.err;
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_oe,
    input logic        cmd_err,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] ctrl_q
);
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe); // R11

    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc); // R10

    AST_REJECT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !busy); // R9

    AST_BUSY_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == 2'd0) |=> (!busy || $stable(ctrl_q))); // R12

    AST_MDC_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy); // R10
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .mdc      (mdc),
    .mdio_oe  (mdio_oe),
    .cmd_err  (cmd_err),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .ctrl_q   (ctrl_q)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        cmd_err, busy, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    mdio_mgmt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_err(cmd_err),
        .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // serial monitor and PHY responder
    logic        mon_clr = 1'b0;
    int          rise_n = 0;
    logic [63:0] cap_o, cap_oe;
    realtime     t0, t1;
    logic        last_rise_o = 1'b1;
    int          hold_bad = 0;
    logic [15:0] phy_rd = 16'h0;

    always @(posedge mdc or posedge mon_clr) begin
        if (mon_clr) begin
            rise_n = 0;
        end else begin
            if (rise_n < 64) begin
                cap_o[63-rise_n]  = mdio_o;
                cap_oe[63-rise_n] = mdio_oe;
            end
            if (rise_n == 0) t0 = $realtime;
            if (rise_n == 1) t1 = $realtime;
            last_rise_o = mdio_o;
            rise_n++;
        end
    end

    always @(negedge mdc) begin
        if (rise_n >= 48 && rise_n < 64) mdio_i = phy_rd[63-rise_n];
    end

    always @(negedge clk) begin
        if (busy && mdc && mdio_o !== last_rise_o) hold_bad++;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // caller is at a negedge; returns at the next negedge
    task automatic write_reg(input logic [1:0] a, input logic [31:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    logic [31:0] data_shadow = 32'h0;

    task automatic run_reject(input logic [31:0] ctrl, input bit is_new, input bit exp_err,
                              input string req);
        logic [31:0] rb;
        write_reg(2'd0, ctrl);
        chk({req, " cmd_err"}, 64'(cmd_err), 64'(exp_err));
        chk({req, " no busy"}, 64'(busy), 64'd0);
        repeat (3) @(negedge clk);
        chk({req, " idle lines"}, {62'd0, busy | mdc, mdio_oe}, 64'd0);
        read_reg(2'd0, rb);
        chk({req, " ctrl readback"}, 64'(rb), 64'(is_new ? (ctrl & ~32'h8000) : ctrl));
        read_reg(2'd1, rb);
        chk({req, " data untouched"}, 64'(rb), 64'(data_shadow));
    endtask

    task automatic run_frame(input logic [31:0] ctrl, input bit is_new, input int half_eff,
                             input logic [15:0] rdv, input bit poke, input string req);
        logic [1:0]  op;
        logic [4:0]  phy, rg;
        logic [15:0] wd;
        bit          rd;
        logic [63:0] ef, eo;
        logic [31:0] rb, exp_data;
        int          cnt, guard;
        if (is_new) begin
            op = ctrl[11:10]; rd = (op == 2'd2);
            phy = ctrl[9:5]; rg = ctrl[4:0]; wd = ctrl[31:16];
        end else begin
            rd = !ctrl[27] && ctrl[26]; op = rd ? 2'b10 : 2'b01;
            phy = ctrl[20:16]; rg = ctrl[25:21]; wd = data_shadow[15:0];
        end
        ef = {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, wd};
        eo = rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
        phy_rd = rdv;
        mon_clr = 1'b1; #1; mon_clr = 1'b0;
        write_reg(2'd0, ctrl);
        chk({req, " busy after command"}, 64'(busy), 64'd1);
        chk({req, " no cmd_err"}, 64'(cmd_err), 64'd0);
        cnt = 0;
        if (poke) begin
            write_reg(2'd0, 32'h0000_0000);
            cnt = 1;
        end
        guard = 0;
        while (busy && guard < 20000) begin
            cnt++; guard++;
            @(negedge clk);
        end
        chk({req, " R11 busy length"}, 64'(cnt), 64'(128 * half_eff));
        chk({req, " R2 frame bits"}, cap_o & eo, ef & eo);
        chk({req, " R11 drive enable pattern"}, cap_oe, eo);
        chk({req, " R10 mdc period"}, 64'(int'((t1 - t0) / CLK_P)), 64'(2 * half_eff));
        chk({req, " R10 mdio stable while mdc high"}, 64'(hold_bad), 64'd0);
        read_reg(2'd0, rb);
        chk({req, " R13 start bit cleared"}, 64'(rb),
            64'(is_new ? (ctrl & ~32'h8000) : (ctrl & ~32'h0C00_0000)));
        exp_data = data_shadow;
        if (rd) exp_data = is_new ? {16'h0, rdv} : {rdv, 16'h0};
        read_reg(2'd1, rb);
        chk({req, rd ? (is_new ? " R6 read data" : " R8 read data") : " data kept"},
            64'(rb), 64'(exp_data));
        data_shadow = exp_data;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1, R10, R11)
        chk("R11 reset busy/oe", {62'd0, busy, mdio_oe}, 64'd0);
        chk("R10 reset mdc", 64'(mdc), 64'd0);
        chk("R3 reset cmd_err", 64'(cmd_err), 64'd0);
        for (int a = 0; a < 3; a++) begin
            read_reg(2'(a), rb);
            chk("R1 reset register", 64'(rb), 64'd0);
        end

        // new layout, half period 1
        write_reg(2'd2, 32'h8000_0001);
        read_reg(2'd2, rb);
        chk("R1 feature readback", 64'(rb), 64'h8000_0001);
        write_reg(2'd1, 32'hDEAD_BEEF);
        data_shadow = 32'hDEAD_BEEF;
        for (int st = 0; st < 2; st++)
            for (int fire = 0; fire < 2; fire++)
                for (int op = 0; op < 4; op++) begin
                    logic [31:0] c;
                    bit ok;
                    c = {16'hA5C3 ^ 16'(op * 16'h1111), 1'(fire), 2'b00, 1'(st), 2'(op),
                         5'(5'h11 + op), 5'(5'h0A + st)};
                    ok = (st == 1) && (fire == 1) && (op == 1 || op == 2);
                    if (ok)
                        run_frame(c, 1'b1, 1, 16'h3C5A ^ 16'(op), 1'b0, "R3 new layout frame");
                    else if (st == 0)
                        run_reject(c, 1'b1, 1'b1, "R4 no clause22 enable");
                    else if (fire == 0)
                        run_reject(c, 1'b1, 1'b0, "R5 fire clear");
                    else
                        run_reject(c, 1'b1, 1'b1, "R3 bad opcode");
                end

        // new layout write at half period 3
        write_reg(2'd2, 32'h8000_0003);
        run_frame({16'h0F1E, 1'b1, 2'b00, 1'b1, 2'd1, 5'h1F, 5'h00}, 1'b1, 3, 16'h0, 1'b0,
                  "R10 half 3 write");

        // legacy layout, half period 2
        write_reg(2'd2, 32'h0000_0002);
        write_reg(2'd1, 32'h1234_5678);
        data_shadow = 32'h1234_5678;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] c;
            c = {4'b0, 1'(k[1]), 1'(k[0]), 5'(5'h03 + k), 5'(5'h1C - k), 16'h0F0F};
            if (k == 0) run_reject(c, 1'b0, 1'b1, "R9 no request");
            else if (k == 1) run_frame(c, 1'b0, 2, 16'hC0DE, 1'b0, "R8 legacy read");
            else if (k == 2) run_frame(c, 1'b0, 2, 16'h0, 1'b0, "R7 legacy write");
            else run_frame(c, 1'b0, 2, 16'hFFFF, 1'b0, "R7 both requests");
        end

        // divider 0 acts as 1; command write while busy ignored
        write_reg(2'd2, 32'h0000_0000);
        run_frame({4'b0, 2'b01, 5'h15, 5'h0B, 16'h0}, 1'b0, 1, 16'h8001, 1'b1,
                  "R12 busy write ignored");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule